// File: doc/BRIEF.md
# Pattern Vector Sequencer with Conditional Loops

The sequencer steps through a program of pattern vectors held in an internal memory. It issues one vector per clock cycle. Each memory word carries the expected pin codes and a match-enable bit, which are handed to a downstream compare stage. It also carries an opcode that chooses the next address. The flow opcodes are plain advance, repeat, loop-count load, loop end, conditional loop exit, unconditional jump, conditional jump and halt.

Conditional opcodes test the failed and matched flags delivered by the compare pipeline. That pipeline has a fixed latency, so a decision made on a given vector reflects a comparison issued a fixed number of vectors earlier. For that reason every opcode, and every iteration of a repeat, takes exactly one cycle. A counted loop can be left early on a condition, and the vector after the loop end is then reached only when the count runs out, which gives a timeout path.

A start pulse begins a burst: the program counter returns to address 0, the counters clear and a one-cycle clear pulse goes to the compare pipeline. The memory is loaded through a simple synchronous write port.

Top module: `patseq_engine`

## Requirements
- R1: After reset, running, halted, vec_valid and cmp_clear are all 0.
- R2: A start pulse sets the address to 0, raises running and clears halted. It produces cmp_clear high for exactly the following cycle, with vec_valid low in that cycle. The vector at address 0 appears one cycle later. A start while running restarts the burst the same way.
- R3: An ordinary vector (opcode 0, or any unassigned code 8 to 15) is emitted with its pin field on vec_pins and its match bit on vec_match_en, and the next address is the following one.
- R4: Repeat (opcode 1) with count n emits the same vector n cycles in a row and then advances. Counts of 0 and 1 both emit it once.
- R5: Set-loop (opcode 2) loads the loop counter with its operand. End-loop (opcode 3) decrements the counter and branches to its operand address while the result is nonzero; otherwise the counter becomes 0 and execution falls through. A loop body bracketed by set-loop n therefore runs n times.
- R6: Exit-if (opcode 4) branches to its operand address and clears the loop counter when its condition holds; otherwise it advances.
- R7: Jump (opcode 5) always branches to its operand address. Jump-if (opcode 6) branches when its condition holds and otherwise advances.
- R8: The condition select codes are 0 = failed, 1 = not failed, 2 = matched and 3 = not matched. They are evaluated on cmp_failed and cmp_matched in the cycle the vector executes.
- R9: Halt (opcode 7) emits its vector, then running drops and halted rises. No vector is emitted afterwards until the next start.
- R10: While running, and with no start pending, exactly one vector is emitted per cycle. Branches insert no gap.
- R11: Memory words written through the write port are executed. The word layout, from the least significant bit, is: pin codes in bits [11:0], match enable in bit 12, condition select in bits [14:13], the 16-bit operand in bits [30:15] and the opcode in bits [34:31]. The branch target is the low 8 bits of the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst start pulse |
| wr_en | input | 1 | Program memory write strobe |
| wr_addr | input | 8 | Program memory write address |
| wr_data | input | 35 | Program memory write word |
| cmp_failed | input | 1 | Sticky failed flag from compare pipeline |
| cmp_matched | input | 1 | Matched flag from compare pipeline |
| running | output | 1 | Burst in progress |
| halted | output | 1 | Burst ended by halt |
| vec_valid | output | 1 | Vector output valid this cycle |
| vec_pins | output | 12 | Expected pin codes of the emitted vector |
| vec_match_en | output | 1 | Match enable of the emitted vector |
| cmp_clear | output | 1 | Clear pulse to the compare pipeline |

## Verification
The assertions check the following on every cycle: the per-opcode address step (hold during a repeat, advance at its end, taken jumps and exits), the loop counter decrement and its clearing on fall-through or exit, the start and clear pulse timing, and the absence of output gaps while running. Only the bench scenarios can show that whole programs produce the right vector order. These include a loop body running exactly n times before the timeout vector, an early exit whose cleared count makes a later loop end fall through, the four condition codes against both flag values, and a restart in the middle of a burst.

// File: rtl/patseq_pkg.sv
package patseq_pkg;

  localparam int OPC_W  = 4;
  localparam int CSEL_W = 2;

  localparam logic [OPC_W-1:0] OP_VEC      = 4'd0;
  localparam logic [OPC_W-1:0] OP_REPEAT   = 4'd1;
  localparam logic [OPC_W-1:0] OP_SET_LOOP = 4'd2;
  localparam logic [OPC_W-1:0] OP_END_LOOP = 4'd3;
  localparam logic [OPC_W-1:0] OP_EXIT_IF  = 4'd4;
  localparam logic [OPC_W-1:0] OP_JUMP     = 4'd5;
  localparam logic [OPC_W-1:0] OP_JUMP_IF  = 4'd6;
  localparam logic [OPC_W-1:0] OP_HALT     = 4'd7;

  // Condition select: 0 failed, 1 not failed, 2 matched, 3 not matched
  function automatic logic cond_eval(input logic [CSEL_W-1:0] sel,
                                     input logic failed,
                                     input logic matched);
    case (sel)
      2'd0:    cond_eval = failed;
      2'd1:    cond_eval = !failed;
      2'd2:    cond_eval = matched;
      default: cond_eval = !matched;
    endcase
  endfunction

endpackage

// File: rtl/patseq_vecmem.sv
module patseq_vecmem #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 35,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Asynchronous read: the vector at the current address executes this cycle
  assign rd_data = store[rd_addr];

endmodule

// File: rtl/patseq_decode.sv
module patseq_decode
  import patseq_pkg::*;
#(
  parameter int PINS    = 4,
  parameter int PCODE_W = 3,
  parameter int CNT_W   = 16,
  localparam int PIN_W    = PINS * PCODE_W,
  localparam int ME_BIT   = PIN_W,
  localparam int CSEL_LSB = PIN_W + 1,
  localparam int OPND_LSB = CSEL_LSB + CSEL_W,
  localparam int OPC_LSB  = OPND_LSB + CNT_W,
  localparam int WORD_W   = OPC_LSB + OPC_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [OPC_W-1:0]  opcode,
  output logic [CNT_W-1:0]  operand,
  output logic [CSEL_W-1:0] cond_sel,
  output logic              match_en,
  output logic [PIN_W-1:0]  pins
);

  assign opcode   = word[OPC_LSB +: OPC_W];
  assign operand  = word[OPND_LSB +: CNT_W];
  assign cond_sel = word[CSEL_LSB +: CSEL_W];
  assign match_en = word[ME_BIT];

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    assign pins[g*PCODE_W +: PCODE_W] = word[g*PCODE_W +: PCODE_W];
  end

endmodule

// File: rtl/patseq_counters.sv
module patseq_counters
  import patseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             exec,
  input  logic [OPC_W-1:0] opcode,
  input  logic [CNT_W-1:0] operand,
  input  logic             cond_hit,
  output logic             rep_done,
  output logic             loop_more,
  output logic [CNT_W-1:0] loop_cnt
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] rep_left;
  logic             rep_active;

  // Remaining repetitions after the first issue of a repeat vector
  function automatic logic [CNT_W-1:0] rep_first(input logic [CNT_W-1:0] n);
    rep_first = (n <= ONE) ? '0 : n - ONE;
  endfunction

  // Loop counter after an end-loop: decrement, saturating at zero
  function automatic logic [CNT_W-1:0] loop_step(input logic [CNT_W-1:0] c);
    loop_step = (c > ONE) ? c - ONE : '0;
  endfunction

  assign rep_active = (rep_left != '0);
  assign rep_done   = (opcode != OP_REPEAT) ||
                      (rep_active ? (rep_left == ONE) : (operand <= ONE));
  assign loop_more  = (loop_cnt > ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_left <= '0;
      loop_cnt <= '0;
    end else if (restart) begin
      rep_left <= '0;
      loop_cnt <= '0;
    end else if (exec) begin
      if (opcode == OP_REPEAT)
        rep_left <= rep_active ? rep_left - ONE : rep_first(operand);
      case (opcode)
        OP_SET_LOOP: loop_cnt <= operand;
        OP_END_LOOP: loop_cnt <= loop_step(loop_cnt);
        OP_EXIT_IF:  if (cond_hit) loop_cnt <= '0;
        default:     loop_cnt <= loop_cnt;
      endcase
    end
  end

endmodule

// File: rtl/patseq_flow.sv
module patseq_flow
  import patseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [ADDR_W-1:0] target,
  input  logic              cond_hit,
  input  logic              rep_done,
  input  logic              loop_more,
  output logic [ADDR_W-1:0] pc_next,
  output logic              halt_now,
  output logic              branch_taken
);

  logic [ADDR_W-1:0] pc_inc;
  assign pc_inc = pc + 1'b1;

  always_comb begin
    branch_taken = 1'b0;
    halt_now     = 1'b0;
    case (opcode)
      OP_JUMP:     branch_taken = 1'b1;
      OP_JUMP_IF,
      OP_EXIT_IF:  branch_taken = cond_hit;
      OP_END_LOOP: branch_taken = loop_more;
      OP_HALT:     halt_now     = 1'b1;
      default:     branch_taken = 1'b0;
    endcase
  end

  always_comb begin
    if (branch_taken)                           pc_next = target;
    else if (halt_now)                          pc_next = pc;
    else if (opcode == OP_REPEAT && !rep_done)  pc_next = pc;
    else                                        pc_next = pc_inc;
  end

endmodule

// File: rtl/patseq_engine.sv
module patseq_engine
  import patseq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PINS    = 4,
  parameter int PCODE_W = 3,
  parameter int CNT_W   = 16,
  localparam int PIN_W  = PINS * PCODE_W,
  localparam int WORD_W = PIN_W + 1 + CSEL_W + CNT_W + OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cmp_failed,
  input  logic              cmp_matched,
  output logic              running,
  output logic              halted,
  output logic              vec_valid,
  output logic [PIN_W-1:0]  vec_pins,
  output logic              vec_match_en,
  output logic              cmp_clear
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_next;
  logic [WORD_W-1:0] cur_word;
  logic [OPC_W-1:0]  cur_op;
  logic [CNT_W-1:0]  cur_operand;
  logic [CSEL_W-1:0] cur_csel;
  logic              cur_me;
  logic [PIN_W-1:0]  cur_pins;
  logic [ADDR_W-1:0] cur_target;
  logic              cond_hit;
  logic              rep_done;
  logic              loop_more;
  logic [CNT_W-1:0]  loop_cnt;
  logic              halt_now;
  logic              branch_taken;
  logic              exec;

  // A vector executes on every running cycle unless a restart is pending
  assign exec       = running && !start;
  assign cur_target = cur_operand[ADDR_W-1:0];
  assign cond_hit   = cond_eval(cur_csel, cmp_failed, cmp_matched);

  patseq_vecmem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (pc_q),
    .rd_data (cur_word)
  );

  patseq_decode #(.PINS(PINS), .PCODE_W(PCODE_W), .CNT_W(CNT_W)) u_dec (
    .word     (cur_word),
    .opcode   (cur_op),
    .operand  (cur_operand),
    .cond_sel (cur_csel),
    .match_en (cur_me),
    .pins     (cur_pins)
  );

  patseq_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start),
    .exec      (exec),
    .opcode    (cur_op),
    .operand   (cur_operand),
    .cond_hit  (cond_hit),
    .rep_done  (rep_done),
    .loop_more (loop_more),
    .loop_cnt  (loop_cnt)
  );

  patseq_flow #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_flow (
    .pc           (pc_q),
    .opcode       (cur_op),
    .target       (cur_target),
    .cond_hit     (cond_hit),
    .rep_done     (rep_done),
    .loop_more    (loop_more),
    .pc_next      (pc_next),
    .halt_now     (halt_now),
    .branch_taken (branch_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q         <= '0;
      running      <= 1'b0;
      halted       <= 1'b0;
      vec_valid    <= 1'b0;
      vec_pins     <= '0;
      vec_match_en <= 1'b0;
      cmp_clear    <= 1'b0;
    end else begin
      cmp_clear <= start;
      vec_valid <= exec;
      if (start) begin
        pc_q    <= '0;
        running <= 1'b1;
        halted  <= 1'b0;
      end else if (exec) begin
        vec_pins     <= cur_pins;
        vec_match_en <= cur_me;
        pc_q         <= pc_next;
        if (halt_now) begin
          running <= 1'b0;
          halted  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/patseq_checker.sv
module patseq_checker
  import patseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              exec,
  input logic              running,
  input logic              halted,
  input logic              vec_valid,
  input logic              cmp_clear,
  input logic [ADDR_W-1:0] pc_q,
  input logic [OPC_W-1:0]  cur_op,
  input logic [ADDR_W-1:0] cur_target,
  input logic              cond_hit,
  input logic              rep_done,
  input logic              loop_more,
  input logic [CNT_W-1:0]  loop_cnt
);

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cmp_clear && running && !halted && !vec_valid && pc_q == '0)); // R2

  AST_EMIT_EACH_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> vec_valid); // R10

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> !vec_valid); // R9

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cur_op == OP_HALT) |=> (!running && halted)); // R9

  AST_HALTED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !running); // R9

  AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cur_op == OP_REPEAT && !rep_done) |=> (pc_q == $past(pc_q))); // R4

  AST_REPEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cur_op == OP_REPEAT && rep_done) |=> (pc_q == $past(pc_q) + 1'b1)); // R4

  AST_LOOP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cur_op == OP_END_LOOP && loop_more)
      |=> (loop_cnt == $past(loop_cnt) - 1'b1 && pc_q == $past(cur_target))); // R5

  AST_LOOP_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cur_op == OP_END_LOOP && !loop_more)
      |=> (loop_cnt == '0 && pc_q == $past(pc_q) + 1'b1)); // R5

  AST_EXIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cur_op == OP_EXIT_IF && cond_hit)
      |=> (loop_cnt == '0 && pc_q == $past(cur_target))); // R6

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cur_op == OP_JUMP) |=> (pc_q == $past(cur_target))); // R7

endmodule

bind patseq_engine patseq_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .exec       (exec),
  .running    (running),
  .halted     (halted),
  .vec_valid  (vec_valid),
  .cmp_clear  (cmp_clear),
  .pc_q       (pc_q),
  .cur_op     (cur_op),
  .cur_target (cur_target),
  .cond_hit   (cond_hit),
  .rep_done   (rep_done),
  .loop_more  (loop_more),
  .loop_cnt   (loop_cnt)
);

// File: tb/patseq_engine_bench.sv
`timescale 1ns/1ps
module patseq_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [34:0] wr_data = '0;
  logic        cmp_failed = 1'b0;
  logic        cmp_matched = 1'b0;
  logic        running, halted, vec_valid, vec_match_en, cmp_clear;
  logic [11:0] vec_pins;

  int checks = 0;
  int errors = 0;
  int    exp_addr[$];
  string exp_tag[$];

  always #5 clk = ~clk;

  patseq_engine u_patseq_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_failed(cmp_failed), .cmp_matched(cmp_matched),
    .running(running), .halted(halted), .vec_valid(vec_valid),
    .vec_pins(vec_pins), .vec_match_en(vec_match_en), .cmp_clear(cmp_clear)
  );

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Word layout per R11: pins = address, match enable = address bit 0
  task automatic put(input int a, input int op, input int opnd, input int csel);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a[7:0];
    wr_data = {op[3:0], opnd[15:0], csel[1:0], a[0], a[11:0]};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic expect_vec(input int a, input string tag);
    exp_addr.push_back(a);
    exp_tag.push_back(tag);
  endtask

  // Scoreboard monitor: each emitted vector must be the next expected one
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_addr.size() == 0) begin
        check(1'b0, "R10 unexpected vector", int'(vec_pins), -1);
      end else begin
        int    a;
        string t;
        a = exp_addr.pop_front();
        t = exp_tag.pop_front();
        check(vec_pins == a[11:0] && vec_match_en == a[0], t, int'(vec_pins), a);
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_burst(input string tag);
    pulse_start();
    check(cmp_clear == 1'b1 && vec_valid == 1'b0 && running == 1'b1, "R2 clear pulse",
          int'({cmp_clear, vec_valid, running}), 3'b101);
    @(negedge clk);
    check(cmp_clear == 1'b0, "R2 clear one cycle", int'(cmp_clear), 0);
    for (int i = 0; i < 2000 && running; i++) @(negedge clk);
    check(!running && halted, "R9 halted state", int'({running, halted}), 1);
    @(negedge clk);
    check(!vec_valid, "R9 no vector after halt", int'(vec_valid), 0);
    check(exp_addr.size() == 0, tag, exp_addr.size(), 0);
    exp_addr.delete();
    exp_tag.delete();
  endtask

  task automatic cond_case(input int csel, input logic f, input logic m, input logic taken);
    put(0, 6, 3, csel);
    cmp_failed  = f;
    cmp_matched = m;
    expect_vec(0, "R8 jump_if vector");
    expect_vec(taken ? 3 : 1, "R8 condition outcome");
    run_burst("R8 jump_if sequence complete");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!running && !halted && !vec_valid && !cmp_clear, "R1 reset outputs",
          int'({running, halted, vec_valid, cmp_clear}), 0);
    rst_n = 1'b1;

    // R3 R4 R11: plain, repeat 3, repeat 0, unassigned opcode, halt
    put(0, 0, 0, 0);
    put(1, 1, 3, 0);
    put(2, 1, 0, 0);
    put(3, 9, 0, 0);
    put(4, 7, 0, 0);
    expect_vec(0, "R3 plain vector");
    for (int i = 0; i < 3; i++) expect_vec(1, "R4 repeat 3");
    expect_vec(2, "R4 repeat 0 once");
    expect_vec(3, "R3 unassigned opcode advances");
    expect_vec(4, "R9 halt vector emitted");
    run_burst("R4 sequence complete");

    // R5 counted loop of 3
    put(0, 2, 3, 0);
    put(1, 0, 0, 0);
    put(2, 3, 1, 0);
    put(3, 7, 0, 0);
    expect_vec(0, "R5 set_loop");
    for (int i = 0; i < 3; i++) begin
      expect_vec(1, "R5 loop body");
      expect_vec(2, "R5 end_loop");
    end
    expect_vec(3, "R5 fall through");
    run_burst("R5 sequence complete");

    // R6 timeout path and early exit on matched
    put(0, 2, 4, 0);
    put(1, 4, 5, 2);
    put(2, 3, 1, 0);
    put(3, 7, 0, 0);
    put(5, 3, 7, 0);
    put(6, 7, 0, 0);
    put(7, 7, 0, 0);
    cmp_matched = 1'b0;
    expect_vec(0, "R6 set_loop");
    for (int i = 0; i < 4; i++) begin
      expect_vec(1, "R6 exit not taken");
      expect_vec(2, "R6 loop end");
    end
    expect_vec(3, "R6 timeout path");
    run_burst("R6 timeout sequence complete");
    cmp_matched = 1'b1;
    expect_vec(0, "R6 set_loop");
    expect_vec(1, "R6 exit vector");
    expect_vec(5, "R6 exit target");
    expect_vec(6, "R6 cleared count falls through");
    run_burst("R6 exit sequence complete");

    // R7 R8 R11: rewritten word 0 with each condition code
    put(1, 7, 0, 0);
    put(3, 7, 0, 0);
    cond_case(0, 1'b1, 1'b0, 1'b1);
    cond_case(0, 1'b0, 1'b1, 1'b0);
    cond_case(1, 1'b0, 1'b0, 1'b1);
    cond_case(1, 1'b1, 1'b0, 1'b0);
    cond_case(2, 1'b0, 1'b1, 1'b1);
    cond_case(2, 1'b1, 1'b0, 1'b0);
    cond_case(3, 1'b0, 1'b1, 1'b0);
    cond_case(3, 1'b1, 1'b0, 1'b1);
    put(0, 5, 3, 0);
    expect_vec(0, "R7 jump vector");
    expect_vec(3, "R7 jump target");
    run_burst("R7 jump sequence complete");

    // R2 R10: restart in mid burst
    put(0, 0, 0, 0);
    put(1, 0, 0, 0);
    put(2, 0, 0, 0);
    put(3, 7, 0, 0);
    expect_vec(0, "R2 first burst");
    expect_vec(1, "R2 first burst");
    for (int i = 0; i < 4; i++) expect_vec(i, "R2 restarted burst");
    pulse_start();
    @(negedge clk);
    run_burst("R2 restart sequence complete");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule